// File: doc/BRIEF.md
# Priority Interrupt Presenter Context

This block holds the interrupt presentation state of one processor thread. Incoming notifications carry a priority from 0 to 7, where a smaller number is more favoured. Each one sets a bit in an 8-bit pending bitmap. A leading-one search turns that bitmap into the most favoured pending priority. Whenever that priority beats the thread's current priority, the block sets an exception flag and raises its interrupt line.

Software changes the current priority through a write strobe. It accepts an interrupt with an acknowledge read strobe. The acknowledge returns a 16-bit status word and always drops the interrupt line. When the exception flag is set, the acknowledge also does four things in one step: it moves the pending priority into the current priority, retires that priority's bitmap bit, recomputes the pending priority, and clears the flag. All four state registers are visible as outputs.

Top module: `prio_presenter_ctx`

## Requirements
- R1: After a synchronous active-low reset, the bitmap is 0x00, the pending priority is 0xFF, the current priority is 0x00, the source byte is 0x00 and `irq_o` is low.
- R2: A notification of priority p in 0..7 sets bitmap bit (7 - p), so priority 0 is bit 7. The new bitmap is visible one cycle after the strobe.
- R3: The pending priority equals the number of leading zeros of the bitmap, which is the index of its leftmost set bit counted from bit 7. It is 0xFF when the bitmap is empty.
- R4: A notification whose priority is in 8..0xFE sets no bitmap bit.
- R5: A notification of priority 0xFF is ignored, and every state output stays unchanged.
- R6: After a notification or a current-priority write, the pending priority is compared with the current priority. If it is numerically smaller, source bit 7 is set and `irq_o` is high on the next cycle. Otherwise neither is raised.
- R7: A current-priority write stores any 8-bit value, and 0xFF unmasks every level. The compare of R6 then runs.
- R8: An acknowledge read drops `irq_o` on the next cycle unless a same-cycle event raises it again.
- R9: An acknowledge while source bit 7 is set does four things. It copies the pending priority into the current priority, clears that priority's bitmap bit, recomputes the pending priority and clears source bit 7.
- R10: An acknowledge while source bit 7 is clear leaves the bitmap, the pending priority, the current priority and the source byte unchanged.
- R11: While `ack_rd_i` is high, `ack_word_o` carries the source byte before the read in bits 15:8 and the current priority that results from the acknowledge in bits 7:0. Otherwise it is zero.
- R12: Source bits 6:0 always read zero.
- R13: In a cycle that has both an acknowledge and a notification or write, the acknowledge is applied first. The write then overrides the current priority, the notification is merged, and the compare runs on the updated state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| note_valid_i | input | 1 | Notification strobe |
| note_prio_i | input | 8 | Priority of the notification |
| cppr_wr_i | input | 1 | Current-priority write strobe |
| cppr_wdata_i | input | 8 | Current-priority write value |
| ack_rd_i | input | 1 | Acknowledge read strobe |
| irq_o | output | 1 | Interrupt line to the thread |
| ack_word_o | output | 16 | Acknowledge status word (source byte, resulting current priority) |
| pend_map_o | output | 8 | Pending-priority bitmap |
| pend_prio_o | output | 8 | Most favoured pending priority |
| cur_prio_o | output | 8 | Current processor priority |
| nsr_o | output | 8 | Source byte, exception flag in bit 7 |

## Verification
The bench targets the bitmap edges. It uses priority 0 at bit 7, priority 7 at bit 0, out-of-range priorities and the 0xFF code. A wrong bit order or a missing range check would corrupt the bitmap or the pending priority. It also exercises an acknowledge with the exception flag clear, which must change nothing, and one with the flag set, whose returned word must still show the old flag. A design that promoted unconditionally, or that sampled the source byte after the update, would fail there. Same-cycle acknowledge plus notification, and acknowledge plus write, catch a design that merged events in the wrong order or skipped the compare on the merged state.

// File: rtl/presenter_pkg.sv
// Package: presenter_pkg
// Shared constants for the interrupt presenter context. Assumes byte-wide
// priority codes with an all-ones code meaning "nothing pending".
package presenter_pkg;
    localparam int PRIO_BITS   = 8;
    localparam int LEVELS      = 8;
    localparam int EXC_BIT     = 7;
    localparam logic [PRIO_BITS-1:0] PRIO_NONE = {PRIO_BITS{1'b1}};
endpackage

// File: rtl/prio_mask_dec.sv
// Module: prio_mask_dec
// Turns a priority code into a one-hot bitmap mask. Priority p maps to bit
// (NUM_PRIO-1-p). Codes at or above NUM_PRIO give an all-zero mask.
// Assumes PRIO_W is wide enough to hold NUM_PRIO-1.
module prio_mask_dec #(
    parameter int NUM_PRIO = 8,
    parameter int PRIO_W   = 8
) (
    input  logic [PRIO_W-1:0]   prio_i,
    output logic [NUM_PRIO-1:0] mask_o
);
    // one comparator per bitmap bit; the most significant bit is priority 0
    for (genvar b = 0; b < NUM_PRIO; b++) begin : g_bit
        assign mask_o[b] = (prio_i == PRIO_W'(NUM_PRIO - 1 - b));
    end
endmodule

// File: rtl/lead_one_enc.sv
// Module: lead_one_enc
// Finds the leftmost set bit of the pending bitmap and reports it as a
// priority, counting from the most significant bit. An empty map gives
// the all-ones code. Purely combinational.
module lead_one_enc #(
    parameter int NUM_PRIO = 8,
    parameter int PRIO_W   = 8
) (
    input  logic [NUM_PRIO-1:0] map_i,
    output logic [PRIO_W-1:0]   prio_o
);
    // scan from least to most favoured so the most favoured hit wins
    always_comb begin
        prio_o = {PRIO_W{1'b1}};
        for (int p = NUM_PRIO - 1; p >= 0; p--) begin
            if (map_i[NUM_PRIO - 1 - p]) prio_o = PRIO_W'(p);
        end
    end
endmodule

// File: rtl/favour_cmp.sv
// Module: favour_cmp
// Decides whether a pending priority beats the current priority.
// A numerically smaller code is more favoured, so the empty code never wins.
module favour_cmp #(
    parameter int PRIO_W = 8
) (
    input  logic [PRIO_W-1:0] pend_i,
    input  logic [PRIO_W-1:0] cur_i,
    output logic              wins_o
);
    // unsigned compare of the two codes
    assign wins_o = (pend_i < cur_i);
endmodule

// File: rtl/prio_presenter_ctx.sv
// Module: prio_presenter_ctx
// Interrupt presenter state for one thread. It holds the pending bitmap, the
// pending priority, the current priority and an exception flag. It merges
// three strobes per cycle in a fixed order: acknowledge, then priority write,
// then notification. The compare runs once on the merged state. Assumes
// strobes are single-cycle and synchronous to clk.
module prio_presenter_ctx
    import presenter_pkg::*;
#(
    parameter int NUM_PRIO = LEVELS,
    parameter int PRIO_W   = PRIO_BITS
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                note_valid_i,
    input  logic [PRIO_W-1:0]   note_prio_i,
    input  logic                cppr_wr_i,
    input  logic [PRIO_W-1:0]   cppr_wdata_i,
    input  logic                ack_rd_i,
    output logic                irq_o,
    output logic [2*PRIO_W-1:0] ack_word_o,
    output logic [NUM_PRIO-1:0] pend_map_o,
    output logic [PRIO_W-1:0]   pend_prio_o,
    output logic [PRIO_W-1:0]   cur_prio_o,
    output logic [PRIO_W-1:0]   nsr_o
);
    localparam logic [PRIO_W-1:0] EMPTY_CODE = {PRIO_W{1'b1}};

    logic [NUM_PRIO-1:0] map_q,  map_after_ack, map_next;
    logic [NUM_PRIO-1:0] clr_mask, set_mask;
    logic [PRIO_W-1:0]   pipr_q, pipr_next;
    logic [PRIO_W-1:0]   cppr_q, cppr_after_ack, cppr_next;
    logic                exc_q, exc_next;
    logic                irq_q, irq_next;
    logic                ack_promote, note_live, cmp_event, favoured, raise;
    logic [PRIO_W-1:0]   nsr_byte;

    // mask of the bit retired by an acknowledge
    prio_mask_dec #(.NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)) u_clr_dec (
        .prio_i (pipr_q),
        .mask_o (clr_mask)
    );

    // mask of the bit set by a notification
    prio_mask_dec #(.NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)) u_set_dec (
        .prio_i (note_prio_i),
        .mask_o (set_mask)
    );

    // most favoured pending priority of the merged bitmap
    lead_one_enc #(.NUM_PRIO(NUM_PRIO), .PRIO_W(PRIO_W)) u_enc (
        .map_i  (map_next),
        .prio_o (pipr_next)
    );

    // pending-versus-current decision on the merged state
    favour_cmp #(.PRIO_W(PRIO_W)) u_cmp (
        .pend_i (pipr_next),
        .cur_i  (cppr_next),
        .wins_o (favoured)
    );

    // source byte with only the exception flag populated
    always_comb begin
        nsr_byte          = '0;
        nsr_byte[EXC_BIT] = exc_q;
    end

    // merge the strobes: acknowledge first, then write, then notification
    always_comb begin
        ack_promote    = ack_rd_i & exc_q;
        note_live      = note_valid_i & (note_prio_i != EMPTY_CODE);
        map_after_ack  = ack_promote ? (map_q & ~clr_mask) : map_q;
        cppr_after_ack = ack_promote ? pipr_q : cppr_q;
        cppr_next      = cppr_wr_i ? cppr_wdata_i : cppr_after_ack;
        map_next       = note_live ? (map_after_ack | set_mask) : map_after_ack;
        cmp_event      = note_live | cppr_wr_i | ack_promote;
        raise          = cmp_event & favoured;
        exc_next       = (exc_q & ~ack_promote) | raise;
        irq_next       = (irq_q & ~ack_rd_i) | raise;
    end

    // state registers with synchronous active-low reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            map_q  <= '0;
            pipr_q <= EMPTY_CODE;
            cppr_q <= '0;
            exc_q  <= 1'b0;
            irq_q  <= 1'b0;
        end else begin
            map_q  <= map_next;
            pipr_q <= pipr_next;
            cppr_q <= cppr_next;
            exc_q  <= exc_next;
            irq_q  <= irq_next;
        end
    end

    // acknowledge status word, zero outside a read
    assign ack_word_o  = ack_rd_i ? {nsr_byte, cppr_after_ack} : '0;
    assign irq_o       = irq_q;
    assign pend_map_o  = map_q;
    assign pend_prio_o = pipr_q;
    assign cur_prio_o  = cppr_q;
    assign nsr_o       = nsr_byte;
endmodule

// File: rtl/presenter_ctx_checker.sv
// Module: presenter_ctx_checker
// Port-level properties of prio_presenter_ctx, attached by bind.
module presenter_ctx_checker #(
    parameter int NUM_PRIO = 8,
    parameter int PRIO_W   = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                note_valid_i,
    input logic [PRIO_W-1:0]   note_prio_i,
    input logic                cppr_wr_i,
    input logic [PRIO_W-1:0]   cppr_wdata_i,
    input logic                ack_rd_i,
    input logic                irq_o,
    input logic [2*PRIO_W-1:0] ack_word_o,
    input logic [NUM_PRIO-1:0] pend_map_o,
    input logic [PRIO_W-1:0]   pend_prio_o,
    input logic [PRIO_W-1:0]   cur_prio_o,
    input logic [PRIO_W-1:0]   nsr_o
);
    localparam logic [PRIO_W-1:0] EMPTY_CODE = {PRIO_W{1'b1}};
    localparam logic [PRIO_W-1:0] LVL        = PRIO_W'(NUM_PRIO);

    p_empty_code_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_map_o == '0) |-> (pend_prio_o == EMPTY_CODE));

    p_leftmost_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (pend_map_o != '0) |-> (pend_prio_o < LVL) &&
            pend_map_o[NUM_PRIO - 1 - int'(pend_prio_o)]);

    p_irq_has_flag_r6: assert property (@(posedge clk) disable iff (!rst_n)
        irq_o |-> nsr_o[PRIO_W-1]);

    p_raise_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid_i && note_prio_i < LVL && note_prio_i < cur_prio_o &&
         !ack_rd_i && !cppr_wr_i) |=> (irq_o && nsr_o[PRIO_W-1]));

    p_ff_ignored_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (note_valid_i && note_prio_i == EMPTY_CODE && !ack_rd_i && !cppr_wr_i)
        |=> ($stable(pend_map_o) && $stable(pend_prio_o) &&
             $stable(cur_prio_o) && $stable(nsr_o) && $stable(irq_o)));

    p_ack_drop_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_i && !note_valid_i && !cppr_wr_i) |=> !irq_o);

    p_promote_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_rd_i && nsr_o[PRIO_W-1] && !cppr_wr_i) |=>
            (cur_prio_o == $past(pend_prio_o)));

    p_word_high_r11: assert property (@(posedge clk) disable iff (!rst_n)
        ack_rd_i |-> (ack_word_o[2*PRIO_W-1:PRIO_W] == nsr_o));

    p_word_idle_r11: assert property (@(posedge clk) disable iff (!rst_n)
        !ack_rd_i |-> (ack_word_o == '0));

    p_rsvd_zero_r12: assert property (@(posedge clk) disable iff (!rst_n)
        nsr_o[PRIO_W-2:0] == '0);

    // write data is only observed through cur_prio_o
    logic unused_ok;
    assign unused_ok = ^cppr_wdata_i;
endmodule

bind prio_presenter_ctx presenter_ctx_checker #(
    .NUM_PRIO (NUM_PRIO),
    .PRIO_W   (PRIO_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .note_valid_i (note_valid_i),
    .note_prio_i  (note_prio_i),
    .cppr_wr_i    (cppr_wr_i),
    .cppr_wdata_i (cppr_wdata_i),
    .ack_rd_i     (ack_rd_i),
    .irq_o        (irq_o),
    .ack_word_o   (ack_word_o),
    .pend_map_o   (pend_map_o),
    .pend_prio_o  (pend_prio_o),
    .cur_prio_o   (cur_prio_o),
    .nsr_o        (nsr_o)
);

// File: tb/tb_prio_presenter_ctx.sv
// Bench for prio_presenter_ctx: directed corner cases followed by seeded
// random strobes. Every step is compared against a bench-side model.
module tb_prio_presenter_ctx;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        note_valid_i = 1'b0;
    logic [7:0]  note_prio_i = '0;
    logic        cppr_wr_i = 1'b0;
    logic [7:0]  cppr_wdata_i = '0;
    logic        ack_rd_i = 1'b0;
    logic        irq_o;
    logic [15:0] ack_word_o;
    logic [7:0]  pend_map_o, pend_prio_o, cur_prio_o, nsr_o;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    // model state
    logic [7:0] m_map, m_pipr, m_cppr;
    logic       m_exc, m_irq;

    always #2.5 clk = ~clk;

    prio_presenter_ctx dut (
        .clk(clk), .rst_n(rst_n),
        .note_valid_i(note_valid_i), .note_prio_i(note_prio_i),
        .cppr_wr_i(cppr_wr_i), .cppr_wdata_i(cppr_wdata_i),
        .ack_rd_i(ack_rd_i), .irq_o(irq_o), .ack_word_o(ack_word_o),
        .pend_map_o(pend_map_o), .pend_prio_o(pend_prio_o),
        .cur_prio_o(cur_prio_o), .nsr_o(nsr_o)
    );

    function automatic logic [7:0] lead_prio(input logic [7:0] m);
        for (int p = 0; p < 8; p++) if (m[7-p]) return 8'(p);
        return 8'hFF;
    endfunction

    task automatic chk(input string req, input logic [15:0] got, input logic [15:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s got=%h exp=%h", req, got, exp);
        end
    endtask

    task automatic chk_state(input string tag);
        chk({tag, " R2 map"},   16'(pend_map_o),  16'(m_map));
        chk({tag, " R3 pipr"},  16'(pend_prio_o), 16'(m_pipr));
        chk({tag, " R7/R9 cur"}, 16'(cur_prio_o), 16'(m_cppr));
        chk({tag, " R6/R12 nsr"}, 16'(nsr_o), 16'({m_exc, 7'b0}));
        chk({tag, " R6/R8 irq"}, 16'(irq_o), 16'(m_irq));
    endtask

    // one clock of stimulus, word check before the edge, state check after
    task automatic step(input string tag, input bit nv, input logic [7:0] np,
                        input bit wr, input logic [7:0] wd, input bit ack);
        bit ev;
        logic [15:0] exp_word;
        @(negedge clk);
        note_valid_i = nv; note_prio_i = np;
        cppr_wr_i = wr; cppr_wdata_i = wd; ack_rd_i = ack;
        exp_word = ack ? {m_exc, 7'b0, (m_exc ? m_pipr : m_cppr)} : 16'h0;
        #1 chk({tag, " R11 word"}, ack_word_o, exp_word);
        ev = 1'b0;
        if (ack) begin
            m_irq = 1'b0;
            if (m_exc) begin
                m_cppr = m_pipr;
                if (m_pipr < 8) m_map[7 - m_pipr] = 1'b0;
                m_exc = 1'b0;
                ev = 1'b1;
            end
        end
        if (wr) begin m_cppr = wd; ev = 1'b1; end
        if (nv && np != 8'hFF) begin
            if (np < 8) m_map[7 - np] = 1'b1;
            ev = 1'b1;
        end
        m_pipr = lead_prio(m_map);
        if (ev && m_pipr < m_cppr) begin m_exc = 1'b1; m_irq = 1'b1; end
        @(posedge clk);
        #1;
        note_valid_i = 1'b0; cppr_wr_i = 1'b0; ack_rd_i = 1'b0;
        chk_state(tag);
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #400000;
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog expired");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1207));
        m_map = 8'h00; m_pipr = 8'hFF; m_cppr = 8'h00; m_exc = 1'b0; m_irq = 1'b0;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        chk("R1 map",  16'(pend_map_o),  16'h00);
        chk("R1 pipr", 16'(pend_prio_o), 16'hFF);
        chk("R1 cur",  16'(cur_prio_o),  16'h00);
        chk("R1 nsr",  16'(nsr_o),       16'h00);
        chk("R1 irq",  16'(irq_o),       16'h0);

        // R2 R3: priority 3 pends but current priority 0 masks it (R6)
        step("d1", 1, 8'd3, 0, 8'd0, 0);
        chk("R2 bit4", 16'(pend_map_o), 16'h10);
        chk("R6 masked", 16'(irq_o), 16'h0);
        // R7: unmask everything, compare raises
        step("d2", 0, 8'd0, 1, 8'hFF, 0);
        chk("R7 raise", 16'({irq_o, nsr_o}), 16'h180);
        // R3: priority 1 becomes leftmost
        step("d3", 1, 8'd1, 0, 8'd0, 0);
        chk("R3 pipr1", 16'(pend_prio_o), 16'h01);
        // R9 R11: acknowledge with flag
        step("d4", 0, 8'd0, 0, 8'd0, 1);
        chk("R9 after", 16'({cur_prio_o, pend_map_o}), 16'h0110);
        chk("R8 low", 16'(irq_o), 16'h0);
        // R10: acknowledge without flag changes nothing
        step("d5", 0, 8'd0, 0, 8'd0, 1);
        chk("R10 hold", 16'({pend_prio_o, cur_prio_o}), 16'h0301);
        // R4 R5: out-of-range and empty codes
        step("d6", 1, 8'h20, 0, 8'd0, 0);
        chk("R4 map", 16'(pend_map_o), 16'h10);
        step("d7", 1, 8'hFF, 0, 8'd0, 0);
        chk("R5 map", 16'(pend_map_o), 16'h10);
        // R13: ack (no flag) with priority 0 notification
        step("d8", 1, 8'd0, 0, 8'd0, 1);
        chk("R13 raise", 16'({irq_o, pend_map_o}), 16'h190);
        // R13: ack (flag) with priority 2 notification, promoted to 0
        step("d9", 1, 8'd2, 0, 8'd0, 1);
        chk("R13 merge", 16'({irq_o, cur_prio_o, pend_map_o}), 16'h0030);
        // R13: ack plus write, write wins
        step("d10", 0, 8'd0, 1, 8'hFF, 1);
        chk("R13 write", 16'(cur_prio_o), 16'h00FF);
        step("d11", 0, 8'd0, 0, 8'd0, 1);
        // R2: priority 7 is bit 0
        step("d12", 1, 8'd7, 1, 8'h08, 0);
        chk("R2 bit0", 16'(pend_map_o[0]), 16'h1);

        for (int i = 0; i < 4000; i++) begin
            bit nv, wr, ack;
            logic [7:0] np, wd;
            int unsigned r;
            nv  = ($urandom % 10) < 4;
            r   = $urandom % 10;
            np  = (r < 7) ? 8'($urandom % 8) : (r < 9) ? 8'(8 + $urandom % 247) : 8'hFF;
            wr  = ($urandom % 100) < 15;
            wd  = (($urandom % 4) == 0) ? 8'hFF : 8'($urandom % 9);
            ack = ($urandom % 4) == 0;
            step("rnd", nv, np, wr, wd, ack);
        end

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule